// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries a 32-bit processor core from normal execution into an exception handler. The core raises one of four request lines: software break, non-maskable interrupt (NMI), bus fault or external interrupt. Alongside the request it presents its architectural state: program counter, current exception return value, status word, stack pointers, pending delay-slot length and the vector table base. The vector numbers for break, bus fault and external interrupt come in from the decoder, the memory management unit and the interrupt controller. The sequencer accepts one request and computes the whole entry frame in the cycle it accepts it. It then reads the handler address from the vector table through a read port with a valid/ready request and a separate response. When the response arrives it reports the new PC together with the register updates the core must commit.

The entry frame works as follows. The return address goes to the exception return register, or for an NMI to the separate NMI return register. A pending delay slot is rolled back so that the interrupted branch runs again. When the core was in user mode the stack pointers are swapped. The status word gets its entry shift: the top two bits stay, the low twenty bits move up by ten, and the low ten bits become zero.

The controller has five states. S_IDLE waits for a request. S_FETCH holds the vector read request until it is accepted. S_WAIT waits for the read data. S_DONE presents the result for one cycle. S_HALT is the absorbing fatal state. The transitions are: S_IDLE to S_FETCH on any request; S_FETCH to S_WAIT on rd_ready; S_WAIT to S_DONE on rsp_valid; S_DONE back to S_IDLE; S_FETCH or S_WAIT to S_HALT when a bus fault is raised during a bus-fault entry. S_HALT is left only by reset.

Top module: `exc_entry_seq`

## Requirements
- R1: A request is accepted only in S_IDLE. When several lines are high, the order of precedence is NMI, then bus fault, then break, then external interrupt. Requests raised while busy or done are ignored; the one exception is the case in R10.
- R2: Software break: the vector comes from trap_vec, and the exception return value is cur_pc + 2 with erp_we = 1.
- R3: NMI: the vector is 0, nrp_we = 1 with nrp_val = cur_pc, and the M flag (status bit 9) is cleared before the entry shift. With no pending delay slot, erp_we = 0.
- R4: Bus fault uses fault_vec and external interrupt uses irq_vec. Both give an exception return value of cur_pc with erp_we = 1.
- R5: A nonzero dslot_len is subtracted from the return value that R2–R4 select (for an NMI this is cur_erp). erp_we is then forced to 1 and dslot_clr is set.
- R6: The vector read address is vec_base + 4 × vector. rd_valid stays high with rd_addr unchanged until rd_ready is seen.
- R7: When the U flag (status bit 8) is set on entry, usp_we = 1 with usp_val = cur_sp and sp_val = kern_sp. Otherwise usp_we = 0 and sp_val = cur_sp.
- R8: status_val = {s[31:30], s[19:0], 10'b0}, where s is cur_status after the NMI M-flag clear.
- R9: busy is high in S_FETCH and S_WAIT. done is high for exactly one cycle, the cycle after rsp_valid, and new_pc then equals the rsp_data received. All frame outputs are valid while done is high.
- R10: A bus-fault request raised in S_FETCH or S_WAIT of a bus-fault entry sends the block to S_HALT. fatal then stays high, and done never rises, until reset.
- R11: After reset, busy, done, fatal and rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_brk | input | 1 | Software break request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_bus | input | 1 | Bus fault request |
| req_irq | input | 1 | External interrupt request |
| trap_vec | input | VEC_W | Vector number for break |
| fault_vec | input | VEC_W | Vector number for bus fault |
| irq_vec | input | VEC_W | Vector number from interrupt controller |
| cur_pc | input | 32 | Current program counter |
| cur_erp | input | 32 | Current exception return register |
| cur_status | input | 32 | Current status word |
| cur_sp | input | 32 | Current stack pointer |
| kern_sp | input | 32 | Kernel stack pointer |
| vec_base | input | 32 | Vector table base address |
| dslot_len | input | DS_W | Pending delay-slot length |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle completion pulse |
| fatal | output | 1 | Nested bus fault, sticky |
| rd_valid | output | 1 | Vector read request valid |
| rd_ready | input | 1 | Vector read request accepted |
| rd_addr | output | 32 | Vector read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data (handler address) |
| new_pc | output | 32 | Handler address |
| erp_we | output | 1 | Write exception return register |
| erp_val | output | 32 | Exception return value |
| nrp_we | output | 1 | Write NMI return register |
| nrp_val | output | 32 | NMI return value |
| usp_we | output | 1 | Write user stack pointer register |
| usp_val | output | 32 | Saved user stack pointer |
| sp_val | output | 32 | New stack pointer |
| status_val | output | 32 | Shifted status word |
| dslot_clr | output | 1 | Clear the delay-slot count |

## Verification
The bench raises all four lines together, and then pairs of lines, to confirm the order of precedence; a reversed priority chain would fetch the wrong vector address. It sends an NMI both with and without a pending delay slot. A design that always writes the exception return register, or never rolls it back for an NMI, shows a wrong erp_we or erp_val. It holds back rd_ready and rsp_valid for several cycles and raises a request in mid-entry, which catches an early done, a moving read address and a request that is taken while busy. It also raises a second bus fault during a bus-fault entry, where a design that nests the fault or recovers from it shows up through done or a dropped fatal.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        K_BRK = 2'd0,
        K_NMI = 2'd1,
        K_BUS = 2'd2,
        K_IRQ = 2'd3
    } exc_kind_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_WAIT  = 3'd2,
        S_DONE  = 3'd3,
        S_HALT  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rd_addr;
        logic              erp_we;
        logic [WORD_W-1:0] erp_val;
        logic              nrp_we;
        logic [WORD_W-1:0] nrp_val;
        logic              usp_we;
        logic [WORD_W-1:0] usp_val;
        logic [WORD_W-1:0] sp_val;
        logic [WORD_W-1:0] status_val;
        logic              dslot_clr;
    } entry_frame_t;

endpackage

// File: rtl/exc_req_arb.sv
module exc_req_arb
    import exc_entry_pkg::*;
(
    input  logic      req_brk,
    input  logic      req_nmi,
    input  logic      req_bus,
    input  logic      req_irq,
    output logic      any_req,
    output exc_kind_t win_kind
);

    // Fixed precedence: NMI, bus fault, break, external interrupt.
    always_comb begin
        any_req = req_brk | req_nmi | req_bus | req_irq;
        if (req_nmi) begin
            win_kind = K_NMI;
        end else if (req_bus) begin
            win_kind = K_BUS;
        end else if (req_brk) begin
            win_kind = K_BRK;
        end else begin
            win_kind = K_IRQ;
        end
    end

endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int DS_W  = 2,
    parameter int M_BIT = 9,
    parameter int U_BIT = 8
) (
    input  exc_kind_t          kind,
    input  logic [VEC_W-1:0]   trap_vec,
    input  logic [VEC_W-1:0]   fault_vec,
    input  logic [VEC_W-1:0]   irq_vec,
    input  logic [WORD_W-1:0]  cur_pc,
    input  logic [WORD_W-1:0]  cur_erp,
    input  logic [WORD_W-1:0]  cur_status,
    input  logic [WORD_W-1:0]  cur_sp,
    input  logic [WORD_W-1:0]  kern_sp,
    input  logic [WORD_W-1:0]  vec_base,
    input  logic [DS_W-1:0]    dslot_len,
    output entry_frame_t       frame
);

    localparam int PAD_W    = WORD_W - VEC_W;
    localparam int KEEP_LO  = 20;
    localparam int SHIFT_BY = 10;

    logic [VEC_W-1:0]  vec;
    logic [WORD_W-1:0] ret_base;
    logic              ret_we;
    logic [WORD_W-1:0] st;
    logic [WORD_W-1:0] vec_off;
    logic              unused_st_mid;

    always_comb begin
        vec      = '0;
        ret_base = cur_pc;
        ret_we   = 1'b1;
        st       = cur_status;
        frame    = '0;
        unique case (kind)
            K_BRK: begin
                vec      = trap_vec;
                ret_base = cur_pc + 32'd2;
            end
            K_NMI: begin
                vec           = '0;
                ret_base      = cur_erp;
                ret_we        = 1'b0;
                st[M_BIT]     = 1'b0;
                frame.nrp_we  = 1'b1;
                frame.nrp_val = cur_pc;
            end
            K_BUS: vec = fault_vec;
            K_IRQ: vec = irq_vec;
        endcase

        // Roll back an interrupted delay slot so the branch re-executes.
        if (dslot_len != '0) begin
            frame.erp_val   = ret_base - {{(WORD_W-DS_W){1'b0}}, dslot_len};
            frame.erp_we    = 1'b1;
            frame.dslot_clr = 1'b1;
        end else begin
            frame.erp_val   = ret_base;
            frame.erp_we    = ret_we;
        end

        vec_off       = {{PAD_W{1'b0}}, vec} << 2;
        frame.rd_addr = vec_base + vec_off;

        // Leaving user mode: park the user stack, switch to kernel stack.
        frame.usp_we  = cur_status[U_BIT];
        frame.usp_val = cur_sp;
        frame.sp_val  = cur_status[U_BIT] ? kern_sp : cur_sp;

        frame.status_val = {st[WORD_W-1:WORD_W-2], st[KEEP_LO-1:0], {SHIFT_BY{1'b0}}};
    end

    assign unused_st_mid = ^st[WORD_W-3:KEEP_LO];

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int DS_W  = 2,
    parameter int M_BIT = 9,   // must be below 10 so the entry shift clears it
    parameter int U_BIT = 8    // must be below 10 so the entry shift clears it
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_brk,
    input  logic              req_nmi,
    input  logic              req_bus,
    input  logic              req_irq,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [VEC_W-1:0]  fault_vec,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [31:0]       cur_pc,
    input  logic [31:0]       cur_erp,
    input  logic [31:0]       cur_status,
    input  logic [31:0]       cur_sp,
    input  logic [31:0]       kern_sp,
    input  logic [31:0]       vec_base,
    input  logic [DS_W-1:0]   dslot_len,
    output logic              busy,
    output logic              done,
    output logic              fatal,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [31:0]       rd_addr,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_data,
    output logic [31:0]       new_pc,
    output logic              erp_we,
    output logic [31:0]       erp_val,
    output logic              nrp_we,
    output logic [31:0]       nrp_val,
    output logic              usp_we,
    output logic [31:0]       usp_val,
    output logic [31:0]       sp_val,
    output logic [31:0]       status_val,
    output logic              dslot_clr
);

    seq_state_t   state_q, state_d;
    exc_kind_t    kind_q, win_kind;
    logic         any_req;
    logic         nest_fault;
    entry_frame_t frame_d, frame_q;
    logic [31:0]  new_pc_q;

    exc_req_arb u_arb (
        .req_brk  (req_brk),
        .req_nmi  (req_nmi),
        .req_bus  (req_bus),
        .req_irq  (req_irq),
        .any_req  (any_req),
        .win_kind (win_kind)
    );

    exc_frame_calc #(
        .VEC_W (VEC_W),
        .DS_W  (DS_W),
        .M_BIT (M_BIT),
        .U_BIT (U_BIT)
    ) u_calc (
        .kind       (win_kind),
        .trap_vec   (trap_vec),
        .fault_vec  (fault_vec),
        .irq_vec    (irq_vec),
        .cur_pc     (cur_pc),
        .cur_erp    (cur_erp),
        .cur_status (cur_status),
        .cur_sp     (cur_sp),
        .kern_sp    (kern_sp),
        .vec_base   (vec_base),
        .dslot_len  (dslot_len),
        .frame      (frame_d)
    );

    assign nest_fault = (kind_q == K_BUS) && req_bus;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (any_req) state_d = S_FETCH;
            S_FETCH: begin
                if (nest_fault)    state_d = S_HALT;
                else if (rd_ready) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (nest_fault)     state_d = S_HALT;
                else if (rsp_valid) state_d = S_DONE;
            end
            S_DONE:  state_d = S_IDLE;
            S_HALT:  state_d = S_HALT;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Frame capture at acceptance, handler address at response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= '0;
            kind_q   <= K_BRK;
            new_pc_q <= '0;
        end else begin
            if (state_q == S_IDLE && any_req) begin
                frame_q <= frame_d;
                kind_q  <= win_kind;
            end
            if (state_q == S_WAIT && rsp_valid && !nest_fault) begin
                new_pc_q <= rsp_data;
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        busy     = (state_q == S_FETCH) || (state_q == S_WAIT);
        done     = (state_q == S_DONE);
        fatal    = (state_q == S_HALT);
        rd_valid = (state_q == S_FETCH);
    end

    assign rd_addr    = frame_q.rd_addr;
    assign new_pc     = new_pc_q;
    assign erp_we     = frame_q.erp_we;
    assign erp_val    = frame_q.erp_val;
    assign nrp_we     = frame_q.nrp_we;
    assign nrp_val    = frame_q.nrp_val;
    assign usp_we     = frame_q.usp_we;
    assign usp_val    = frame_q.usp_val;
    assign sp_val     = frame_q.sp_val;
    assign status_val = frame_q.status_val;
    assign dslot_clr  = frame_q.dslot_clr;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R9
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rsp_valid));                          // R9
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                           // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !req_bus) |=> (rd_valid && $stable(rd_addr))); // R6
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> (fatal && !done));                                // R10
    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_val[9:0] == 10'd0));                       // R8
    AST_NRP_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && nrp_we) |-> (rd_addr == vec_base));            // R3

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_brk = 0, req_nmi = 0, req_bus = 0, req_irq = 0;
    logic [7:0]  trap_vec = 8'd5, fault_vec = 8'd9, irq_vec = 8'd33;
    logic [31:0] cur_pc = 32'h0000_1000, cur_erp = 32'h0000_0700;
    logic [31:0] cur_status = 32'h0000_0000, cur_sp = 32'h0001_0000, kern_sp = 32'h0002_0000;
    logic [31:0] vec_base = 32'h8000_0000;
    logic [1:0]  dslot_len = 2'd0;
    logic rd_ready = 0, rsp_valid = 0;
    logic [31:0] rsp_data = 0;
    logic busy, done, fatal, rd_valid, erp_we, nrp_we, usp_we, dslot_clr;
    logic [31:0] rd_addr, new_pc, erp_val, nrp_val, usp_val, sp_val, status_val;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .req_brk(req_brk), .req_nmi(req_nmi), .req_bus(req_bus), .req_irq(req_irq),
        .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
        .cur_pc(cur_pc), .cur_erp(cur_erp), .cur_status(cur_status),
        .cur_sp(cur_sp), .kern_sp(kern_sp), .vec_base(vec_base), .dslot_len(dslot_len),
        .busy(busy), .done(done), .fatal(fatal), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .new_pc(new_pc), .erp_we(erp_we), .erp_val(erp_val), .nrp_we(nrp_we),
        .nrp_val(nrp_val), .usp_we(usp_we), .usp_val(usp_val), .sp_val(sp_val),
        .status_val(status_val), .dslot_clr(dslot_clr)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model: phase 0 idle, 1 fetch, 2 wait, 3 done, 4 halt.
    int ph = 0;
    int m_kind = 0;   // 0 brk, 1 nmi, 2 bus, 3 irq
    logic [31:0] e_addr, e_erp, e_nrp, e_usp, e_sp, e_st, e_pc;
    logic e_erpw, e_nrpw, e_uspw, e_dclr;

    function automatic logic [31:0] entry_shift(input logic [31:0] s);
        return (s & 32'hC000_0000) | (((s << 12) >> 2) & ~32'h0000_03FF);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = 0;
        end else begin
            case (ph)
                0: if (req_brk || req_nmi || req_bus || req_irq) begin
                    logic [31:0] v, rb, s;
                    m_kind = req_nmi ? 1 : req_bus ? 2 : req_brk ? 0 : 3;
                    s = cur_status;
                    e_nrpw = 0; e_nrp = 0; e_erpw = 1; rb = cur_pc;
                    case (m_kind)
                        0: begin v = trap_vec; rb = cur_pc + 2; end
                        1: begin v = 0; rb = cur_erp; e_erpw = 0; e_nrpw = 1; e_nrp = cur_pc;
                                 s = s & ~(32'd1 << 9); end
                        2: v = fault_vec;
                        default: v = irq_vec;
                    endcase
                    e_dclr = (dslot_len != 0);
                    e_erp = rb - dslot_len;
                    if (e_dclr) e_erpw = 1;
                    e_addr = vec_base + v * 4;
                    e_uspw = cur_status[8];
                    e_usp = e_uspw ? cur_sp : 32'h0;
                    e_sp = e_uspw ? kern_sp : cur_sp;
                    e_st = entry_shift(s);
                    ph = 1;
                end
                1: if (m_kind == 2 && req_bus) ph = 4; else if (rd_ready) ph = 2;
                2: if (m_kind == 2 && req_bus) ph = 4; else if (rsp_valid) begin ph = 3; e_pc = rsp_data; end
                3: ph = 0;
                default: ph = 4;
            endcase
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        check(busy == (ph == 1 || ph == 2), "R9/R11 busy", busy, (ph == 1 || ph == 2));
        check(done == (ph == 3), "R9/R11 done", done, (ph == 3));
        check(fatal == (ph == 4), "R10/R11 fatal", fatal, (ph == 4));
        check(rd_valid == (ph == 1), "R6/R11 rd_valid", rd_valid, (ph == 1));
        if (ph == 1) check(rd_addr == e_addr, "R6 rd_addr (R1 winner)", rd_addr, e_addr);
        if (ph == 3) begin
            check(new_pc == e_pc, "R9 new_pc", new_pc, e_pc);
            check(erp_we == e_erpw, "R2/R3/R4/R5 erp_we", erp_we, e_erpw);
            if (e_erpw) check(erp_val == e_erp, "R2/R4/R5 erp_val", erp_val, e_erp);
            check(nrp_we == e_nrpw, "R3 nrp_we", nrp_we, e_nrpw);
            if (e_nrpw) check(nrp_val == e_nrp, "R3 nrp_val", nrp_val, e_nrp);
            check(dslot_clr == e_dclr, "R5 dslot_clr", dslot_clr, e_dclr);
            check(usp_we == e_uspw, "R7 usp_we", usp_we, e_uspw);
            if (e_uspw) check(usp_val == e_usp, "R7 usp_val", usp_val, e_usp);
            check(sp_val == e_sp, "R7 sp_val", sp_val, e_sp);
            check(status_val == e_st, "R8 status_val", status_val, e_st);
        end
    end

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary_and_end();
        end
    end

    // One full entry: requests held one cycle, then read handshake with delays.
    task automatic entry(input logic b, input logic n, input logic bu, input logic i,
                         input int rdy_dly, input int rsp_dly, input logic [31:0] data,
                         input logic poke);
        @(negedge clk);
        req_brk = b; req_nmi = n; req_bus = bu; req_irq = i;
        @(negedge clk);
        req_brk = 0; req_nmi = 0; req_bus = 0; req_irq = 0;
        if (poke) begin req_irq = 1; req_brk = 1; end   // R1: ignored while busy
        repeat (rdy_dly) @(negedge clk);
        rd_ready = 1;
        @(negedge clk);
        rd_ready = 0;
        repeat (rsp_dly) @(negedge clk);
        rsp_valid = 1; rsp_data = data;
        @(negedge clk);
        rsp_valid = 0; req_irq = 0; req_brk = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: break from kernel mode
        entry(1, 0, 0, 0, 0, 0, 32'h0000_4000, 0);
        // R3 R7 R8: NMI from user mode with M set, no delay slot
        cur_status = 32'hC00F_F3A5;
        entry(0, 1, 0, 0, 2, 3, 32'h0000_4100, 0);
        // R3 R5: NMI with a delay slot pending
        dslot_len = 2'd1;
        entry(0, 1, 0, 0, 1, 1, 32'h0000_4200, 0);
        // R4 R5: bus fault with a two-byte delay slot
        dslot_len = 2'd2; cur_status = 32'h0000_0100; cur_pc = 32'h0000_2222;
        entry(0, 0, 1, 0, 0, 2, 32'h0000_4300, 0);
        // R4 R6: external interrupt, top vector, slow handshake, R1 poke while busy
        dslot_len = 2'd0; irq_vec = 8'hFF; cur_status = 32'h3FFF_FFFF;
        entry(0, 0, 0, 1, 4, 5, 32'h0000_4400, 1);
        // R1: precedence
        entry(1, 1, 1, 1, 0, 0, 32'h0000_4500, 0);
        entry(1, 0, 1, 1, 1, 0, 32'h0000_4600, 0);
        entry(1, 0, 0, 1, 0, 1, 32'h0000_4700, 0);
        // R10: nested bus fault while waiting for the vector
        @(negedge clk); req_bus = 1;
        @(negedge clk); req_bus = 0; rd_ready = 1;
        @(negedge clk); rd_ready = 0;
        @(negedge clk); req_bus = 1;
        @(negedge clk); req_bus = 0; rsp_valid = 1; rsp_data = 32'h0000_4800;
        @(negedge clk); rsp_valid = 0;
        repeat (4) @(negedge clk);
        check(fatal == 1'b1, "R10 fatal held", fatal, 1);
        // R11: reset leaves the halt state
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(!busy && !done && !fatal && !rd_valid, "R11 reset outputs",
              {busy, done, fatal, rd_valid}, 0);
        rst_n = 1;
        entry(1, 0, 0, 0, 0, 0, 32'h0000_4900, 0);
        summary_and_end();
    end

endmodule